// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers three interrupt causes from a graphics engine and turns them into a single interrupt line. It also holds the overflow memory pool that the binner uses. Two causes are latched events: the binner has finished flushing, and a frame has finished rendering. Software acknowledges a latched event by writing a 1 to its status bit. The third cause reports that the binner has run out of memory. That bit is not latched: it reflects the state of the overflow pool for as long as the condition lasts.

Software controls one enable mask through two write registers. Writing 1s to the arm register sets mask bits, and writing 1s to the disarm register clears them. Both registers read back the same mask. The interrupt line is registered and is high whenever a pending cause is also enabled.

A small state machine tracks the overflow pool. It has three states:
- `POOL_STARVED`: the binner has no memory. This is the state after reset.
- `POOL_BASE_HELD`: software has written a base address, but the pool still has no size.
- `POOL_FED`: memory has been supplied.

It has these transitions:
- `base_write` (STARVED to BASE_HELD): software writes the base address.
- `size_write_nonzero` (BASE_HELD to FED): software writes a nonzero size.
- `exhausted` (FED to STARVED): the engine reports that the pool is used up.

Any other stimulus leaves the state where it is, and the base and size registers still take every write made to them.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset, the latched status bits, the enable mask, the pool base and the pool size are all 0, and `irq` is low. The pool is starved, so the status register (word 0) reads 4.
- R2: Status bit 0 (frame done) and bit 1 (flush done) set on a high event input. Each stays set until software writes a 1 to that bit of word 0. Writing 0 bits to word 0 changes nothing.
- R3: If an event and a write-1 clear reach the same latched bit in the same cycle, the bit stays set.
- R4: Writing to the arm register (word 1) sets each mask bit whose data bit is 1. Bits written as 0 keep their value.
- R5: Writing to the disarm register (word 2) clears each mask bit whose data bit is 1. Bits written as 0 keep their value.
- R6: Reading word 1 and reading word 2 both return the current mask in bits 2:0.
- R7: `irq` is registered. It goes high one cycle after (status AND mask) becomes nonzero, and goes low one cycle after it becomes zero.
- R8: Status bit 2 (out of memory) is 1 whenever the pool is not fed. Writing a 1 to bit 2 does not clear it while the pool is still starved.
- R9: The pool becomes fed only when a write of the base address (word 3) is followed by a nonzero write of the size (word 4). A size write with no base written first, or a size write of 0, leaves bit 2 set.
- R10: An `evt_pool_exhausted` pulse while the pool is fed makes bit 2 read 1 on the next cycle. The pool then needs a new base write and a new size write before it is fed again.
- R11: Bits 31:3 of words 0 to 2 read 0 and ignore writes. Words 5 to 7 read 0, and writes to them change no state.
- R12: Writing 7 to word 0 clears both latched bits in one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_frame_done | input | 1 | Render frame done event |
| evt_flush_done | input | 1 | Binner flush done event |
| evt_pool_exhausted | input | 1 | Binner has used up its overflow pool |
| pool_base | output | 32 | Overflow pool base address sent to the binner |
| pool_size | output | 32 | Overflow pool size sent to the binner |
| irq | output | 1 | Registered interrupt line |

## Verification
Single event pulses on each latched source show that the two latched bits are kept apart. A pulse that lands in the same cycle as its own clear shows that the event takes priority over the clear. The arm and disarm registers are written with one-hot values, with all-zero values and with values that have upper bits set. This separates set-only behaviour from plain overwrite behaviour, and shows that the upper bits are masked off. The pool writes are issued in the wrong order, with a zero size, and in the right order. This shows that only the sequence of a base write followed by a nonzero size write feeds the binner. It also shows that the out-of-memory bit follows that condition and that a write-1 acknowledge does not clear it.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;

    localparam int NUM_SRC   = 3;
    localparam int SRC_FRAME = 0;
    localparam int SRC_FLUSH = 1;
    localparam int SRC_OOM   = 2;
    localparam int NUM_LATCH = 2;

    typedef enum logic [2:0] {
        WORD_STATUS = 3'd0,
        WORD_ARM    = 3'd1,
        WORD_DISARM = 3'd2,
        WORD_BASE   = 3'd3,
        WORD_SIZE   = 3'd4
    } word_e;

    typedef enum logic [1:0] {
        POOL_STARVED   = 2'd0,
        POOL_BASE_HELD = 2'd1,
        POOL_FED       = 2'd2
    } pool_state_e;

endpackage

// File: rtl/gfx_irq_latch.sv
module gfx_irq_latch
    import gfx_irq_pkg::*;
#(
    parameter int N = NUM_LATCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (evt[i]) begin
                pend[i] <= 1'b1;
            end else if (ack[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gfx_irq_mask.sv
module gfx_irq_mask #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm_we,
    input  logic         disarm_we,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (arm_we) begin
            mask <= mask | bits;
        end else if (disarm_we) begin
            mask <= mask & ~bits;
        end
    end

endmodule

// File: rtl/gfx_pool_fsm.sv
module gfx_pool_fsm
    import gfx_irq_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic          size_we,
    input  logic [AW-1:0] base_in,
    input  logic [SW-1:0] size_in,
    input  logic          exhausted,
    output logic [AW-1:0] base_q,
    output logic [SW-1:0] size_q,
    output logic          starved
);

    pool_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POOL_STARVED:   if (base_we) state_d = POOL_BASE_HELD;
            POOL_BASE_HELD: if (size_we && (size_in != '0)) state_d = POOL_FED;
            POOL_FED:       if (exhausted) state_d = POOL_STARVED;
            default:        state_d = POOL_STARVED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POOL_STARVED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else begin
            if (base_we) base_q <= base_in;
            if (size_we) size_q <= size_in;
        end
    end

    always_comb begin
        starved = (state_q != POOL_FED);
    end

endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
    import gfx_irq_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr_en,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          evt_frame_done,
    input  logic          evt_flush_done,
    input  logic          evt_pool_exhausted,
    output logic [AW-1:0] pool_base,
    output logic [SW-1:0] pool_size,
    output logic          irq
);

    logic                 we_status, we_arm, we_disarm, we_base, we_size;
    logic [NUM_LATCH-1:0] latch_evt, latch_ack, latch_pend;
    logic [NUM_SRC-1:0]   status_w, mask_w;
    logic                 starved_w;
    logic                 irq_q;

    always_comb begin
        we_status = reg_wr_en && (reg_addr == WORD_STATUS);
        we_arm    = reg_wr_en && (reg_addr == WORD_ARM);
        we_disarm = reg_wr_en && (reg_addr == WORD_DISARM);
        we_base   = reg_wr_en && (reg_addr == WORD_BASE);
        we_size   = reg_wr_en && (reg_addr == WORD_SIZE);
    end

    always_comb begin
        latch_evt[SRC_FRAME] = evt_frame_done;
        latch_evt[SRC_FLUSH] = evt_flush_done;
        latch_ack            = we_status ? reg_wdata[NUM_LATCH-1:0] : '0;
    end

    gfx_irq_latch #(.N(NUM_LATCH)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (latch_evt),
        .ack  (latch_ack),
        .pend (latch_pend)
    );

    gfx_irq_mask #(.N(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_we   (we_arm),
        .disarm_we(we_disarm),
        .bits     (reg_wdata[NUM_SRC-1:0]),
        .mask     (mask_w)
    );

    gfx_pool_fsm #(.AW(AW), .SW(SW)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_we  (we_base),
        .size_we  (we_size),
        .base_in  (reg_wdata[AW-1:0]),
        .size_in  (reg_wdata[SW-1:0]),
        .exhausted(evt_pool_exhausted),
        .base_q   (pool_base),
        .size_q   (pool_size),
        .starved  (starved_w)
    );

    always_comb begin
        status_w = {starved_w, latch_pend};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_w & mask_w);
        end
    end

    always_comb begin
        irq = irq_q;
        reg_rdata = '0;
        unique case (reg_addr)
            WORD_STATUS: reg_rdata[NUM_SRC-1:0] = status_w;
            WORD_ARM:    reg_rdata[NUM_SRC-1:0] = mask_w;
            WORD_DISARM: reg_rdata[NUM_SRC-1:0] = mask_w;
            WORD_BASE:   reg_rdata[AW-1:0]      = pool_base;
            WORD_SIZE:   reg_rdata[SW-1:0]      = pool_size;
            default:     reg_rdata              = '0;
        endcase
    end

endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  reg_addr,
    input logic        reg_wr_en,
    input logic [31:0] reg_wdata,
    input logic        evt_frame_done,
    input logic        evt_pool_exhausted,
    input logic        irq,
    input logic [2:0]  status_v,
    input logic [2:0]  mask_v
);

    AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame_done |=> status_v[0]); // R3

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_v[1] && !(reg_wr_en && reg_addr == 3'd0 && reg_wdata[1])) |=> status_v[1]); // R2

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 3'd1) |=> ((mask_v & $past(reg_wdata[2:0])) == $past(reg_wdata[2:0]))); // R4

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 3'd2) |=> ((mask_v & $past(reg_wdata[2:0])) == 3'd0)); // R5

    AST_NO_IRQ_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_v == 3'd0) |=> !irq); // R7

    AST_OOM_ACK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 3'd0 && reg_wdata[2] && status_v[2]) |=> status_v[2]); // R8

    AST_EXHAUST_STARVES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pool_exhausted && !status_v[2]) |=> status_v[2]); // R10

endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .reg_addr          (reg_addr),
    .reg_wr_en         (reg_wr_en),
    .reg_wdata         (reg_wdata),
    .evt_frame_done    (evt_frame_done),
    .evt_pool_exhausted(evt_pool_exhausted),
    .irq               (irq),
    .status_v          (status_w),
    .mask_v            (mask_w)
);

// File: tb/gfx_irq_ctrl_test.sv
module gfx_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_frame_done = 1'b0;
    logic        evt_flush_done = 1'b0;
    logic        evt_pool_exhausted = 1'b0;
    logic [31:0] pool_base, pool_size;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gfx_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_frame_done(evt_frame_done), .evt_flush_done(evt_flush_done),
        .evt_pool_exhausted(evt_pool_exhausted),
        .pool_base(pool_base), .pool_size(pool_size), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input bit fr, input bit fl, input bit ex);
        @(negedge clk);
        evt_frame_done = fr; evt_flush_done = fl; evt_pool_exhausted = ex;
        @(negedge clk);
        evt_frame_done = 0; evt_flush_done = 0; evt_pool_exhausted = 0;
    endtask

    task automatic t_reset();
        rd_check("R1 status", 3'd0, 32'h4);
        rd_check("R1 mask", 3'd1, 32'h0);
        rd_check("R1 base", 3'd3, 32'h0);
        rd_check("R1 size", 3'd4, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_latch();
        pulse(1, 0, 0);
        rd_check("R2 frame set", 3'd0, 32'h5);
        pulse(0, 1, 0);
        rd_check("R2 flush set", 3'd0, 32'h7);
        wr(3'd0, 32'h0);
        rd_check("R2 zero write", 3'd0, 32'h7);
        wr(3'd0, 32'h1);
        rd_check("R2 ack frame", 3'd0, 32'h6);
        wr(3'd0, 32'h2);
        rd_check("R2 ack flush", 3'd0, 32'h4);
    endtask

    task automatic t_collision();
        @(negedge clk);
        evt_frame_done = 1; reg_addr = 3'd0; reg_wdata = 32'h1; reg_wr_en = 1;
        @(negedge clk);
        evt_frame_done = 0; reg_wr_en = 0; reg_wdata = '0;
        rd_check("R3 event wins", 3'd0, 32'h5);
        wr(3'd0, 32'h1);
        rd_check("R3 later ack", 3'd0, 32'h4);
    endtask

    task automatic t_enable();
        wr(3'd1, 32'h3);
        rd_check("R4 arm", 3'd1, 32'h3);
        rd_check("R6 disarm readback", 3'd2, 32'h3);
        wr(3'd1, 32'h0);
        rd_check("R4 zero arm", 3'd1, 32'h3);
        wr(3'd2, 32'h1);
        rd_check("R5 disarm", 3'd2, 32'h2);
        wr(3'd2, 32'h0);
        rd_check("R5 zero disarm", 3'd1, 32'h2);
        wr(3'd1, 32'hFFFF_FFFC);
        rd_check("R11 upper bits", 3'd1, 32'h6);
        wr(3'd2, 32'h7);
        rd_check("R5 disarm all", 3'd1, 32'h0);
    endtask

    task automatic t_irq();
        wr(3'd1, 32'h2);
        check("R7 idle irq", {31'b0, irq}, 32'h0);
        pulse(0, 1, 0);
        check("R7 irq lag", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R7 irq high", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h2);
        check("R7 irq hold", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R7 irq low", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h2);
    endtask

    task automatic t_oom();
        wr(3'd1, 32'h4);
        @(negedge clk);
        check("R8 oom irq", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h4);
        rd_check("R8 ack ignored", 3'd0, 32'h4);
        wr(3'd2, 32'h4);
        @(negedge clk);
        check("R7 disarmed low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_pool();
        wr(3'd4, 32'h100);
        rd_check("R9 size first", 3'd0, 32'h4);
        wr(3'd3, 32'h8000_0000);
        rd_check("R9 base only", 3'd0, 32'h4);
        wr(3'd4, 32'h0);
        rd_check("R9 zero size", 3'd0, 32'h4);
        wr(3'd4, 32'h200);
        rd_check("R9 fed", 3'd0, 32'h0);
        check("R9 base out", pool_base, 32'h8000_0000);
        check("R9 size out", pool_size, 32'h200);
        rd_check("R9 size read", 3'd4, 32'h200);
    endtask

    task automatic t_exhaust();
        pulse(0, 0, 1);
        rd_check("R10 starved", 3'd0, 32'h4);
        wr(3'd4, 32'h300);
        rd_check("R10 needs base", 3'd0, 32'h4);
        wr(3'd3, 32'h9000_0000);
        wr(3'd4, 32'h300);
        rd_check("R10 refed", 3'd0, 32'h0);
    endtask

    task automatic t_unused();
        wr(3'd1, 32'h1);
        wr(3'd6, 32'hFFFF_FFFF);
        rd_check("R11 word5", 3'd5, 32'h0);
        rd_check("R11 word6", 3'd6, 32'h0);
        rd_check("R11 word7", 3'd7, 32'h0);
        rd_check("R11 mask kept", 3'd1, 32'h1);
        rd_check("R11 status kept", 3'd0, 32'h0);
        wr(3'd2, 32'h1);
    endtask

    task automatic t_bulk();
        pulse(1, 1, 0);
        rd_check("R12 both set", 3'd0, 32'h3);
        wr(3'd0, 32'h7);
        rd_check("R12 bulk clear", 3'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_collision();
        t_enable();
        t_irq();
        t_oom();
        t_pool();
        t_exhaust();
        t_unused();
        t_bulk();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule